// File: doc/BRIEF.md
# Audio serial bit and frame clock divider

This block derives the two timing clocks that an audio serial port needs from a single master audio clock. The bit clock is the master clock divided by 2 or by 4. The frame clock, which marks the left and right channel halves, is derived from the bit clock rather than from the master clock. It is divided by 32, 64 or 128 bit-clock periods. Both outputs are registered square waves with 50% duty cycle, and both sit on the master clock domain.

All settings come from one packed control word. One bit enables the block, one bit picks the bit-clock ratio and a three-bit field picks the frame-clock ratio. When the block is disabled, both outputs are held low and the counters are cleared, so every enable starts from the same low phase. The frame clock changes only at the master edge on which the bit clock falls, which keeps the two clocks phase-aligned for the serial data logic downstream. A frame select code that names no ratio is rejected. The last valid ratio stays in force and an error flag is raised.

Top module: `aclk_divider`

## Requirements
- R1: With control bit 16 at 0, the bit clock toggles on every enabled master edge (divide by 2). With bit 16 at 1, it toggles on every second enabled edge (divide by 4). Both ratios give 50% duty.
- R2: Frame select field bits 19:17 set the frame clock period: code 0 gives 32 bit-clock periods, code 1 gives 64 and code 2 gives 128. The frame clock is high for exactly half of its period.
- R3: The frame clock changes only at a master edge on which the bit clock goes from 1 to 0.
- R4: While control bit 15 (enable) is 0, both clocks are low from the next master edge onward.
- R5: After the enable is first sampled high, both clocks start in the low phase with cleared counters. The bit clock rises at enabled edge H, where H is 1 for divide by 2 and 2 for divide by 4. The frame clock rises after half a frame period.
- R6: A frame select code of 3 to 7 sets sel_err_o high from the next master edge, and the last valid frame ratio stays in use, also across a disable.
- R7: A frame select code of 0 to 2 clears sel_err_o from the next master edge and takes effect without delay.
- R8: After reset, both clocks and sel_err_o are low, and the held frame ratio is 32 bit-clock periods.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master audio clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctrl_i | input | 32 | Control word: bit 15 enable, bit 16 bit-clock select, bits 19:17 frame select |
| bclk_o | output | 1 | Serial bit clock |
| lrclk_o | output | 1 | Frame (left/right) clock |
| sel_err_o | output | 1 | Frame select code is invalid |

## Verification
The bench builds the block with its default parameters: ratios 2 and 4 for the bit clock, and a base of 32 for the frame clock, which gives 32, 64 and 128. At these values, a full frame period takes at most 512 master cycles. The bench can therefore run all six ratio pairs for two complete frame periods each and compare every sample against a closed-form expectation. The same short periods let the bench place an invalid select in the middle of a run and across a disable, then confirm that the held ratio continues the waveform unchanged.

// File: rtl/aclk_pkg.sv
package aclk_pkg;
  localparam int unsigned CTRL_W = 32;
  localparam int unsigned EN_POS = 15;
  localparam int unsigned BSEL_POS = 16;
  localparam int unsigned FSEL_POS = 17;
  localparam int unsigned FSEL_W = 3;

  typedef struct packed {
    logic                enable;
    logic                bit_sel;
    logic [FSEL_W-1:0]   frame_sel;
  } aclk_ctrl_t;

  function automatic aclk_ctrl_t unpack_ctrl(input logic [CTRL_W-1:0] word);
    aclk_ctrl_t c;
    c.enable    = word[EN_POS];
    c.bit_sel   = word[BSEL_POS];
    c.frame_sel = word[FSEL_POS +: FSEL_W];
    return c;
  endfunction
endpackage

// File: rtl/aclk_ctrl_decode.sv
module aclk_ctrl_decode
  import aclk_pkg::*;
#(
  parameter int unsigned FRAME_RATIOS = 3,
  localparam int unsigned FIDX_W = $clog2(FRAME_RATIOS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CTRL_W-1:0] ctrl_word_i,
  output logic              enable_o,
  output logic              bit_sel_o,
  output logic [FIDX_W-1:0] frame_idx_o,
  output logic              sel_err_o
);
  aclk_ctrl_t  ctrl;
  logic        sel_ok;
  logic [FIDX_W-1:0] held_q;
  logic        err_q;
  logic        unused_bits;

  assign ctrl        = unpack_ctrl(ctrl_word_i);
  assign unused_bits = ^ctrl_word_i;
  assign sel_ok      = (ctrl.frame_sel < FSEL_W'(FRAME_RATIOS));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      held_q <= '0;
      err_q  <= 1'b0;
    end else begin
      err_q <= !sel_ok;
      if (sel_ok) held_q <= ctrl.frame_sel[FIDX_W-1:0];
    end
  end

  // valid codes take effect at once, invalid ones fall back to the held ratio
  assign frame_idx_o = sel_ok ? ctrl.frame_sel[FIDX_W-1:0] : held_q;
  assign enable_o    = ctrl.enable;
  assign bit_sel_o   = ctrl.bit_sel;
  assign sel_err_o   = err_q;
endmodule

// File: rtl/aclk_bit_div.sv
module aclk_bit_div #(
  parameter int unsigned DIV_LO = 2,
  parameter int unsigned DIV_HI = 4,
  localparam int unsigned HALF_LO = DIV_LO / 2,
  localparam int unsigned HALF_HI = DIV_HI / 2,
  localparam int unsigned CNT_W = $clog2(HALF_HI + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic enable_i,
  input  logic bit_sel_i,
  output logic bclk_o,
  output logic fall_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] half;
  logic             wrap;
  logic             bclk_q;

  assign half = bit_sel_i ? CNT_W'(HALF_HI) : CNT_W'(HALF_LO);
  assign wrap = (cnt_q >= half - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      bclk_q <= 1'b0;
    end else if (!enable_i) begin
      cnt_q  <= '0;
      bclk_q <= 1'b0;
    end else if (wrap) begin
      cnt_q  <= '0;
      bclk_q <= !bclk_q;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end

  // high when this edge takes the bit clock from 1 to 0
  assign fall_o = enable_i && wrap && bclk_q;
  assign bclk_o = bclk_q;
endmodule

// File: rtl/aclk_frame_div.sv
module aclk_frame_div #(
  parameter int unsigned FRAME_BASE   = 32,
  parameter int unsigned FRAME_RATIOS = 3,
  localparam int unsigned FIDX_W   = $clog2(FRAME_RATIOS),
  localparam int unsigned MAX_HALF = (FRAME_BASE << (FRAME_RATIOS - 1)) / 2,
  localparam int unsigned CNT_W    = $clog2(MAX_HALF + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              enable_i,
  input  logic              fall_i,
  input  logic [FIDX_W-1:0] frame_idx_i,
  output logic              lrclk_o
);
  logic [CNT_W-1:0] half_tab [FRAME_RATIOS];
  logic [CNT_W-1:0] half;
  logic [CNT_W-1:0] cnt_q;
  logic             lr_q;

  for (genvar g = 0; g < FRAME_RATIOS; g++) begin : g_half
    assign half_tab[g] = CNT_W'((FRAME_BASE << g) / 2);
  end

  always_comb begin
    half = half_tab[0];
    for (int i = 0; i < FRAME_RATIOS; i++)
      if (frame_idx_i == FIDX_W'(i)) half = half_tab[i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      lr_q  <= 1'b0;
    end else if (!enable_i) begin
      cnt_q <= '0;
      lr_q  <= 1'b0;
    end else if (fall_i) begin
      if (cnt_q >= half - 1'b1) begin
        cnt_q <= '0;
        lr_q  <= !lr_q;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign lrclk_o = lr_q;
endmodule

// File: rtl/aclk_divider.sv
module aclk_divider
  import aclk_pkg::*;
#(
  parameter int unsigned BIT_DIV_LO   = 2,
  parameter int unsigned BIT_DIV_HI   = 4,
  parameter int unsigned FRAME_BASE   = 32,
  parameter int unsigned FRAME_RATIOS = 3,
  localparam int unsigned FIDX_W = $clog2(FRAME_RATIOS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CTRL_W-1:0] ctrl_i,
  output logic              bclk_o,
  output logic              lrclk_o,
  output logic              sel_err_o
);
  logic              enable;
  logic              bit_sel;
  logic [FIDX_W-1:0] frame_idx;
  logic              bclk_fall;

  aclk_ctrl_decode #(.FRAME_RATIOS(FRAME_RATIOS)) i_decode (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ctrl_word_i (ctrl_i),
    .enable_o    (enable),
    .bit_sel_o   (bit_sel),
    .frame_idx_o (frame_idx),
    .sel_err_o   (sel_err_o)
  );

  aclk_bit_div #(.DIV_LO(BIT_DIV_LO), .DIV_HI(BIT_DIV_HI)) i_bit_div (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .enable_i  (enable),
    .bit_sel_i (bit_sel),
    .bclk_o    (bclk_o),
    .fall_o    (bclk_fall)
  );

  aclk_frame_div #(.FRAME_BASE(FRAME_BASE), .FRAME_RATIOS(FRAME_RATIOS)) i_frame_div (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .enable_i    (enable),
    .fall_i      (bclk_fall),
    .frame_idx_i (frame_idx),
    .lrclk_o     (lrclk_o)
  );
endmodule

// File: rtl/aclk_divider_chk.sv
module aclk_divider_chk
  import aclk_pkg::*;
#(
  parameter int unsigned FRAME_RATIOS = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [CTRL_W-1:0] ctrl_i,
  input logic              bclk_o,
  input logic              lrclk_o,
  input logic              sel_err_o
);
  aclk_ctrl_t c;
  logic       sel_bad;
  logic       unused_bits;

  assign c           = unpack_ctrl(ctrl_i);
  assign sel_bad     = (c.frame_sel >= FSEL_W'(FRAME_RATIOS));
  assign unused_bits = ^ctrl_i;

  AST_OFF_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !c.enable |=> (!bclk_o && !lrclk_o)); // R4
  AST_DIV2_TOGGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (c.enable && !c.bit_sel) |=> (bclk_o != $past(bclk_o))); // R1
  AST_DIV4_START_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (c.enable && c.bit_sel && !$past(c.enable)) |=> !bclk_o); // R5
  AST_LR_ON_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(c.enable) && (lrclk_o != $past(lrclk_o))) |-> $fell(bclk_o)); // R3
  AST_ERR_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_bad |=> sel_err_o); // R6
  AST_ERR_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_bad |=> !sel_err_o); // R7
endmodule

bind aclk_divider aclk_divider_chk #(.FRAME_RATIOS(FRAME_RATIOS)) i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .ctrl_i    (ctrl_i),
  .bclk_o    (bclk_o),
  .lrclk_o   (lrclk_o),
  .sel_err_o (sel_err_o)
);

// File: tb/test_aclk_divider.sv
module test_aclk_divider;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic        bsel;
    logic [2:0]  fsel;
    int unsigned half;
    int unsigned ratio;
  } vec_t;

  localparam int NVEC = 6;
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 3'd0, 1, 32},
    '{1'b1, 3'd0, 2, 32},
    '{1'b0, 3'd1, 1, 64},
    '{1'b1, 3'd1, 2, 64},
    '{1'b0, 3'd2, 1, 128},
    '{1'b1, 3'd2, 2, 128}
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] ctrl_i = '0;
  logic        bclk_o, lrclk_o, sel_err_o;

  int total = 0;
  int bad = 0;
  int n_edge = 0;
  logic prev_b, prev_l;
  bit done = 0;

  aclk_divider i_aclk_divider (
    .clk_i(clk_i), .rst_ni(rst_ni), .ctrl_i(ctrl_i),
    .bclk_o(bclk_o), .lrclk_o(lrclk_o), .sel_err_o(sel_err_o)
  );

  always #(CLK_PERIOD/2) clk_i = !clk_i;

  function automatic logic [31:0] mk(input logic en, input logic bsel, input logic [2:0] fsel);
    logic [31:0] w = '0;
    w[15] = en;
    w[16] = bsel;
    w[19:17] = fsel;
    return w;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic start_run(input logic bsel, input logic [2:0] fsel);
    @(negedge clk_i);
    ctrl_i = mk(1'b1, bsel, fsel);
    n_edge = 0;
    prev_b = 1'b0;
    prev_l = 1'b0;
  endtask

  // advance count edges, compare each sample with the closed-form waveform
  task automatic advance(input int unsigned half, input int unsigned ratio, input int count, input string tag);
    int bmis = 0, lmis = 0, fmis = 0;
    int ba = 0, be = 0, la = 0, le = 0;
    for (int k = 0; k < count; k++) begin
      logic eb, el;
      @(posedge clk_i); #1;
      n_edge++;
      eb = 1'((n_edge / half) % 2);
      el = 1'((n_edge / (half * ratio)) % 2);
      if (bclk_o !== eb) begin
        if (bmis == 0) begin ba = int'(bclk_o); be = int'(eb); end
        bmis++;
      end
      if (lrclk_o !== el) begin
        if (lmis == 0) begin la = int'(lrclk_o); le = int'(el); end
        lmis++;
      end
      if ((lrclk_o !== prev_l) && !(prev_b === 1'b1 && bclk_o === 1'b0)) fmis++;
      prev_b = bclk_o;
      prev_l = lrclk_o;
    end
    check(bmis == 0, {"R1 bit clock ", tag}, ba, be);
    check(lmis == 0, {"R2 frame clock ", tag}, la, le);
    check(fmis == 0, {"R3 frame edge off bit fall ", tag}, fmis, 0);
  endtask

  task automatic stop_run(input logic bsel, input logic [2:0] fsel);
    @(negedge clk_i);
    ctrl_i = mk(1'b0, bsel, fsel);
    @(posedge clk_i); #1;
    check(bclk_o == 1'b0 && lrclk_o == 1'b0, "R4 outputs low after disable",
          int'({bclk_o, lrclk_o}), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1;
    // R8: reset state
    check(bclk_o == 1'b0 && lrclk_o == 1'b0 && sel_err_o == 1'b0, "R8 reset outputs",
          int'({bclk_o, lrclk_o, sel_err_o}), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    // R8: invalid code straight after reset falls back to ratio 32
    start_run(1'b0, 3'd7);
    advance(1, 32, 130, "R8 held ratio after reset");
    check(sel_err_o == 1'b1, "R6 error flag on code 7", int'(sel_err_o), 1);
    stop_run(1'b0, 3'd0);

    // table walk: all ratio pairs for two frame periods
    for (int v = 0; v < NVEC; v++) begin
      start_run(VECS[v].bsel, VECS[v].fsel);
      advance(VECS[v].half, VECS[v].ratio, int'(2 * 2 * VECS[v].half * VECS[v].ratio),
              $sformatf("vec %0d", v));
      stop_run(VECS[v].bsel, VECS[v].fsel);
    end

    // R5: defined low start for divide by 4
    start_run(1'b1, 3'd0);
    @(posedge clk_i); #1;
    check(bclk_o == 1'b0 && lrclk_o == 1'b0, "R5 low after first enabled edge",
          int'({bclk_o, lrclk_o}), 0);
    @(posedge clk_i); #1;
    check(bclk_o == 1'b1, "R5 bit clock rises at edge 2", int'(bclk_o), 1);
    stop_run(1'b1, 3'd0);
    repeat (5) @(posedge clk_i);
    #1;
    check(bclk_o == 1'b0 && lrclk_o == 1'b0, "R4 outputs stay low while disabled",
          int'({bclk_o, lrclk_o}), 0);

    // R6/R7: invalid code mid-run keeps the 64 ratio
    start_run(1'b0, 3'd1);
    advance(1, 64, 100, "R6 before invalid");
    @(negedge clk_i);
    ctrl_i = mk(1'b1, 1'b0, 3'd6);
    advance(1, 64, 1, "R6 edge of invalid");
    check(sel_err_o == 1'b1, "R6 error flag on code 6", int'(sel_err_o), 1);
    advance(1, 64, 200, "R6 held ratio mid-run");
    @(negedge clk_i);
    ctrl_i = mk(1'b1, 1'b0, 3'd1);
    advance(1, 64, 1, "R7 edge of valid");
    check(sel_err_o == 1'b0, "R7 error flag cleared", int'(sel_err_o), 0);
    stop_run(1'b0, 3'd1);

    // R6: hold survives a disable
    @(negedge clk_i);
    ctrl_i = mk(1'b0, 1'b1, 3'd3);
    @(posedge clk_i); #1;
    check(sel_err_o == 1'b1, "R6 error flag while disabled", int'(sel_err_o), 1);
    start_run(1'b1, 3'd3);
    advance(2, 64, 2 * 2 * 64 + 10, "R6 held ratio across disable");
    stop_run(1'b1, 3'd2);
    check(sel_err_o == 1'b0, "R7 error flag cleared by code 2", int'(sel_err_o), 0);

    // R7: valid change while disabled takes effect at once
    start_run(1'b0, 3'd2);
    advance(1, 128, 300, "R7 new ratio at enable");
    stop_run(1'b0, 3'd2);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule